// File: doc/BRIEF.md
# Operand Address Generator

This block turns one decoded operand reference of an 8-bit accumulator-style microcontroller into an effective address and a target memory space. It receives the addressing-mode code, the 3-bit register field, the direct address byte, the two bank-select bits, the accumulator, the stack pointer, the contents of the two pointer registers of the current bank, the 16-bit data pointer and the program counter. For each request it works out the address and sends it to one of four spaces: internal data RAM, special function registers, external data memory, or program memory. For the computed-jump mode it returns the new program counter value.

The result is registered. A small state machine holds one of three states. `S_IDLE` means no request was taken on the last edge. `S_ISSUE` means a legal request was accepted, and the registered address and space are presented with `valid_o` high. `S_FAULT` means an illegal combination was seen, so `err_o` is high and no strobe is given. The state machine has no memory beyond one cycle. On every edge it goes to `S_ISSUE` if a legal request is present, to `S_FAULT` if an illegal request is present, and to `S_IDLE` if there is no request. This holds whatever the current state is.

Mode codes (`mode`): 0 direct, 1 register, 2 pointer-register indirect, 3 stack-pointer indirect, 4 data-pointer indirect, 5 immediate, 6 indexed code read, 7 computed jump. Space codes (`space_o`): 0 internal RAM, 1 special function register, 2 external data, 3 program memory.

Top module: `opaddr_gen`

## Requirements
- R1: In mode 0 the address is `dir_addr`. The space is 0 when `dir_addr` < 0x80 and 1 when `dir_addr` >= 0x80.
- R2: In mode 1 the address is `bank`*8 + `reg_sel`, and the space is 0.
- R3: In mode 2 the address is `ptr0` when `reg_sel` is 0 and `ptr1` when `reg_sel` is 1. The space is 2 when `ext_sel` is 1 and 0 otherwise. It is never 1, even for addresses of 0x80 and above.
- R4: In mode 3 the address is `sp` and the space is 0.
- R5: In mode 4 the address is `dptr` and the space is 2. `ext_sel` has no effect.
- R6: In mode 5 the address is `pc` and the space is 3.
- R7: In mode 6 the address is (base + `acc`) mod 65536, where the base is `dptr` when `reg_sel` is 0 and `pc` when `reg_sel` is 1. The space is 3 and `jump_o` is 0.
- R8: In mode 7 the address is the same sum as in R7, with space 3 and `jump_o` 1.
- R9: A request is illegal when `reg_sel` > 1 in modes 2, 6 or 7, or when `ext_sel` is 1 in modes 0, 1 or 3. An illegal request gives `err_o` 1 and `valid_o` 0 in the next cycle.
- R10: A request sampled on a rising edge gives its result after that same edge, for exactly one cycle. When `req` is low on an edge, `valid_o` and `err_o` are low after it.
- R11: While `rst_n` is low, `valid_o`, `err_o` and `jump_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Operand address request |
| mode | input | 3 | Addressing-mode code |
| reg_sel | input | 3 | Register field from the opcode |
| ext_sel | input | 1 | Selects external data for pointer-register indirection |
| dir_addr | input | 8 | Direct address byte |
| bank | input | 2 | Register bank select |
| acc | input | 8 | Accumulator |
| sp | input | 8 | Stack pointer |
| ptr0 | input | 8 | Contents of register 0 of the current bank |
| ptr1 | input | 8 | Contents of register 1 of the current bank |
| dptr | input | 16 | Data pointer |
| pc | input | 16 | Program counter (points past the current opcode) |
| valid_o | output | 1 | Legal result strobe |
| err_o | output | 1 | Illegal request flag |
| jump_o | output | 1 | Result is a jump destination |
| space_o | output | 2 | Target space code |
| addr_o | output | 16 | Effective address |

## Verification
Every result passes through one register stage. A wrong state or a wrong captured address therefore shows at the ports one cycle after the request that caused it: as a wrong `addr_o` or `space_o`, as `valid_o` and `err_o` swapped, or as a strobe that persists into an idle cycle. Because the state is rebuilt on every edge, an error cannot linger, and each request's outputs expose it alone. The sweeps cover every direct address, every bank and register pair, and carry-out of the 16-bit index sum, so an error in a single bit or a single boundary is seen on the request that hits it.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        M_DIRECT = 3'd0,
        M_REG    = 3'd1,
        M_IND8   = 3'd2,
        M_INDSP  = 3'd3,
        M_IND16  = 3'd4,
        M_IMM    = 3'd5,
        M_IDX    = 3'd6,
        M_JMP    = 3'd7
    } mode_e;

    typedef enum logic [1:0] {
        SP_IRAM = 2'd0,
        SP_SFR  = 2'd1,
        SP_XDAT = 2'd2,
        SP_CODE = 2'd3
    } space_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_FAULT = 2'd2
    } state_e;
endpackage

// File: rtl/opaddr_bank.sv
module opaddr_bank #(
    parameter int AW = 16,
    parameter int RW = 3,
    parameter int BW = 2
) (
    input  logic [BW-1:0] bank,
    input  logic [RW-1:0] reg_sel,
    output logic [AW-1:0] loc
);
    localparam int PAD = AW - BW - RW;

    // bank * 2^RW + register number, zero-extended
    assign loc = {{PAD{1'b0}}, bank, reg_sel};
endmodule

// File: rtl/opaddr_index.sv
module opaddr_index #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          use_pc,
    input  logic [AW-1:0] dptr,
    input  logic [AW-1:0] pc,
    input  logic [DW-1:0] acc,
    output logic [AW-1:0] sum
);
    localparam int PAD = AW - DW;
    logic [AW-1:0] base;

    assign base = use_pc ? pc : dptr;
    assign sum  = base + {{PAD{1'b0}}, acc};
endmodule

// File: rtl/opaddr_route.sv
module opaddr_route
    import opaddr_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int RW = 3
) (
    input  mode_e         mode,
    input  logic [RW-1:0] reg_sel,
    input  logic          ext_sel,
    input  logic [DW-1:0] dir_addr,
    input  logic [DW-1:0] sp,
    input  logic [DW-1:0] ptr0,
    input  logic [DW-1:0] ptr1,
    input  logic [AW-1:0] dptr,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] bank_loc,
    input  logic [AW-1:0] idx_sum,
    output logic [AW-1:0] addr,
    output space_e        space,
    output logic          jump,
    output logic          legal
);
    localparam int PAD = AW - DW;
    logic ptr_ok;

    assign ptr_ok = (reg_sel[RW-1:1] == '0);

    always_comb begin
        addr  = '0;
        space = SP_IRAM;
        jump  = 1'b0;
        legal = 1'b1;
        unique case (mode)
            M_DIRECT: begin
                addr  = {{PAD{1'b0}}, dir_addr};
                space = dir_addr[DW-1] ? SP_SFR : SP_IRAM;
                legal = !ext_sel;
            end
            M_REG: begin
                addr  = bank_loc;
                legal = !ext_sel;
            end
            M_IND8: begin
                addr  = {{PAD{1'b0}}, (reg_sel[0] ? ptr1 : ptr0)};
                space = ext_sel ? SP_XDAT : SP_IRAM;
                legal = ptr_ok;
            end
            M_INDSP: begin
                addr  = {{PAD{1'b0}}, sp};
                legal = !ext_sel;
            end
            M_IND16: begin
                addr  = dptr;
                space = SP_XDAT;
            end
            M_IMM: begin
                addr  = pc;
                space = SP_CODE;
            end
            M_IDX: begin
                addr  = idx_sum;
                space = SP_CODE;
                legal = ptr_ok;
            end
            M_JMP: begin
                addr  = idx_sum;
                space = SP_CODE;
                jump  = 1'b1;
                legal = ptr_ok;
            end
        endcase
    end
endmodule

// File: rtl/opaddr_gen.sv
module opaddr_gen
    import opaddr_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int RW = 3,
    parameter int BW = 2,
    parameter int MW = 3,
    parameter int SW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [MW-1:0] mode,
    input  logic [RW-1:0] reg_sel,
    input  logic          ext_sel,
    input  logic [DW-1:0] dir_addr,
    input  logic [BW-1:0] bank,
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] sp,
    input  logic [DW-1:0] ptr0,
    input  logic [DW-1:0] ptr1,
    input  logic [AW-1:0] dptr,
    input  logic [AW-1:0] pc,
    output logic          valid_o,
    output logic          err_o,
    output logic          jump_o,
    output logic [SW-1:0] space_o,
    output logic [AW-1:0] addr_o
);
    state_e        state, state_nx;
    logic [AW-1:0] bank_loc, idx_sum, addr_c, addr_q;
    space_e        space_c, space_q;
    logic          jump_c, jump_q, legal_c;
    mode_e         mode_c;

    assign mode_c = mode_e'(mode);

    opaddr_bank #(.AW(AW), .RW(RW), .BW(BW)) u_bank (
        .bank    (bank),
        .reg_sel (reg_sel),
        .loc     (bank_loc)
    );

    opaddr_index #(.AW(AW), .DW(DW)) u_index (
        .use_pc (reg_sel[0]),
        .dptr   (dptr),
        .pc     (pc),
        .acc    (acc),
        .sum    (idx_sum)
    );

    opaddr_route #(.AW(AW), .DW(DW), .RW(RW)) u_route (
        .mode     (mode_c),
        .reg_sel  (reg_sel),
        .ext_sel  (ext_sel),
        .dir_addr (dir_addr),
        .sp       (sp),
        .ptr0     (ptr0),
        .ptr1     (ptr1),
        .dptr     (dptr),
        .pc       (pc),
        .bank_loc (bank_loc),
        .idx_sum  (idx_sum),
        .addr     (addr_c),
        .space    (space_c),
        .jump     (jump_c),
        .legal    (legal_c)
    );

    // Next-state: every state reacts to the request on this edge alone
    always_comb begin
        state_nx = S_IDLE;
        unique case (state)
            S_IDLE, S_ISSUE, S_FAULT: begin
                if (req) state_nx = legal_c ? S_ISSUE : S_FAULT;
                else     state_nx = S_IDLE;
            end
            default: state_nx = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Result capture for accepted requests
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            space_q <= SP_IRAM;
            jump_q  <= 1'b0;
        end else if (req && legal_c) begin
            addr_q  <= addr_c;
            space_q <= space_c;
            jump_q  <= jump_c;
        end
    end

    // Outputs from state
    always_comb begin
        valid_o = 1'b0;
        err_o   = 1'b0;
        unique case (state)
            S_IDLE:  ;
            S_ISSUE: valid_o = 1'b1;
            S_FAULT: err_o   = 1'b1;
            default: ;
        endcase
        jump_o  = valid_o && jump_q;
        space_o = space_q;
        addr_o  = addr_q;
    end
endmodule

// File: rtl/opaddr_gen_chk.sv
module opaddr_gen_chk #(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int RW = 3,
    parameter int BW = 2,
    parameter int MW = 3,
    parameter int SW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req,
    input logic [MW-1:0] mode,
    input logic [RW-1:0] reg_sel,
    input logic          ext_sel,
    input logic [DW-1:0] dir_addr,
    input logic [BW-1:0] bank,
    input logic [DW-1:0] acc,
    input logic [DW-1:0] sp,
    input logic [DW-1:0] ptr0,
    input logic [DW-1:0] ptr1,
    input logic [AW-1:0] dptr,
    input logic [AW-1:0] pc,
    input logic          valid_o,
    input logic          err_o,
    input logic          jump_o,
    input logic [SW-1:0] space_o,
    input logic [AW-1:0] addr_o
);
    localparam int PAD = AW - BW - RW;

    p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && err_o));

    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> (!valid_o && !err_o));

    p_sfr_direct_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req && mode != 3'd0) |=> !(valid_o && space_o == 2'd1));

    p_reg_loc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && mode == 3'd1 && !ext_sel) |=>
        (valid_o && space_o == 2'd0 &&
         addr_o == {{PAD{1'b0}}, $past(bank), $past(reg_sel)}));

    p_ind16_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req && mode == 3'd4) |=>
        (valid_o && space_o == 2'd2 && addr_o == $past(dptr)));

    p_jump_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        jump_o |-> (valid_o && space_o == 2'd3));

    p_badptr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req && mode == 3'd2 && reg_sel > 3'd1) |=> (err_o && !valid_o));

    always_comb begin
        if (!rst_n) begin
            a_reset_r11: assert (!valid_o && !err_o && !jump_o);
        end
    end
endmodule

bind opaddr_gen opaddr_gen_chk #(
    .AW(AW), .DW(DW), .RW(RW), .BW(BW), .MW(MW), .SW(SW)
) u_chk (.*);

// File: tb/opaddr_gen_bench.sv
module opaddr_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [2:0]  mode = '0;
    logic [2:0]  reg_sel = '0;
    logic        ext_sel = 1'b0;
    logic [7:0]  dir_addr = '0;
    logic [1:0]  bank = '0;
    logic [7:0]  acc = '0;
    logic [7:0]  sp = '0;
    logic [7:0]  ptr0 = '0;
    logic [7:0]  ptr1 = '0;
    logic [15:0] dptr = '0;
    logic [15:0] pc = '0;
    logic        valid_o, err_o, jump_o;
    logic [1:0]  space_o;
    logic [15:0] addr_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    opaddr_gen u_opaddr_gen (
        .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .reg_sel(reg_sel),
        .ext_sel(ext_sel), .dir_addr(dir_addr), .bank(bank), .acc(acc),
        .sp(sp), .ptr0(ptr0), .ptr1(ptr1), .dptr(dptr), .pc(pc),
        .valid_o(valid_o), .err_o(err_o), .jump_o(jump_o),
        .space_o(space_o), .addr_o(addr_o)
    );

    // {legal, jump, space[1:0], addr[15:0]} from the requirements
    function automatic logic [19:0] model();
        logic        lg = 1'b1;
        logic        jp = 1'b0;
        logic [1:0]  s  = 2'd0;
        logic [15:0] a  = 16'd0;
        logic [15:0] base = reg_sel[0] ? pc : dptr;
        case (mode)
            3'd0: begin a = {8'd0, dir_addr}; s = (dir_addr >= 8'h80) ? 2'd1 : 2'd0; lg = !ext_sel; end
            3'd1: begin a = 16'(bank) * 16'd8 + 16'(reg_sel); lg = !ext_sel; end
            3'd2: begin a = {8'd0, reg_sel[0] ? ptr1 : ptr0}; s = ext_sel ? 2'd2 : 2'd0; lg = (reg_sel <= 3'd1); end
            3'd3: begin a = {8'd0, sp}; lg = !ext_sel; end
            3'd4: begin a = dptr; s = 2'd2; end
            3'd5: begin a = pc; s = 2'd3; end
            3'd6: begin a = base + 16'(acc); s = 2'd3; lg = (reg_sel <= 3'd1); end
            default: begin a = base + 16'(acc); s = 2'd3; jp = 1'b1; lg = (reg_sel <= 3'd1); end
        endcase
        return {lg, jp, s, a};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called at a falling edge with the operand inputs already set
    task automatic fire(input string tag);
        logic [19:0] e;
        req = 1'b1;
        @(negedge clk);
        e = model();
        check(tag, {31'd0, valid_o}, {31'd0, e[19]});
        check(tag, {31'd0, err_o}, {31'd0, !e[19]});
        if (e[19]) begin
            check(tag, {16'd0, addr_o}, {16'd0, e[15:0]});
            check(tag, {30'd0, space_o}, {30'd0, e[17:16]});
            check(tag, {31'd0, jump_o}, {31'd0, e[18]});
        end
        req = 1'b0;
    endtask

    task automatic idle(input string tag);
        req = 1'b0;
        @(negedge clk);
        check(tag, {30'd0, valid_o, err_o}, 32'd0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", {29'd0, valid_o, err_o, jump_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", {29'd0, valid_o, err_o, jump_o}, 32'd0);

        // R1: every direct address
        mode = 3'd0;
        for (int d = 0; d < 256; d++) begin
            dir_addr = 8'(d);
            fire("R1");
        end

        // R2: every bank and register
        mode = 3'd1;
        for (int b = 0; b < 4; b++)
            for (int r = 0; r < 8; r++) begin
                bank = 2'(b); reg_sel = 3'(r);
                fire("R2");
            end

        // R3: pointer registers, high addresses stay in RAM space
        mode = 3'd2; ptr0 = 8'h9A; ptr1 = 8'h05;
        for (int r = 0; r < 2; r++)
            for (int x = 0; x < 2; x++) begin
                reg_sel = 3'(r); ext_sel = 1'(x);
                fire("R3");
            end
        ptr1 = 8'hFF; reg_sel = 3'd1; ext_sel = 1'b0;
        fire("R3");

        // R4: stack pointer
        mode = 3'd3; ext_sel = 1'b0;
        sp = 8'h07; fire("R4");
        sp = 8'hF0; fire("R4");

        // R5: data pointer, ext_sel has no effect
        mode = 3'd4; dptr = 16'hBEEF;
        ext_sel = 1'b0; fire("R5");
        ext_sel = 1'b1; fire("R5");
        ext_sel = 1'b0;

        // R10: idle cycle after a request
        idle("R10");

        // R6: immediate
        mode = 3'd5; pc = 16'h1234; fire("R6");

        // R7/R8: indexed read and computed jump, with carry and wrap
        for (int m = 6; m < 8; m++)
            for (int r = 0; r < 2; r++)
                for (int a = 0; a < 256; a += 17) begin
                    mode = 3'(m); reg_sel = 3'(r); acc = 8'(a);
                    dptr = 16'hFFF0; pc = 16'h00FF;
                    fire(m == 6 ? "R7" : "R8");
                end

        // R9: illegal combinations
        mode = 3'd2; ext_sel = 1'b0;
        for (int r = 2; r < 8; r++) begin reg_sel = 3'(r); fire("R9"); end
        mode = 3'd6;
        for (int r = 2; r < 8; r++) begin reg_sel = 3'(r); fire("R9"); end
        mode = 3'd7; reg_sel = 3'd7; fire("R9");
        reg_sel = 3'd0; ext_sel = 1'b1;
        mode = 3'd0; fire("R9");
        mode = 3'd1; fire("R9");
        mode = 3'd3; fire("R9");
        ext_sel = 1'b0;

        // R10: fault cleared by an idle cycle, then a legal request
        idle("R10");
        mode = 3'd4; dptr = 16'h0001; fire("R10");
        idle("R10");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule